// File: doc/BRIEF.md
# XOR-Encoded Multiport Memory

This block is a memory with several write ports and several read ports, all active in the same clock cycle. It is built only from simple banks that each have one write port and one read port. Each write port owns a set of banks. A write does not store its raw data. It stores the data XORed with what every other write port's set currently holds at that address. A read then XORs the values at its address across all sets, and this rebuilds the most recent value written there. No table is needed to track which port wrote an address last.

With NW write ports and NR read ports there are NW sets of NW-1+NR banks each, so NW*(NW-1+NR) banks in total. In each set, NR banks serve the read ports. The other NW-1 banks serve the old-data lookups of the other write ports. All banks in a set receive the same write address and the same encoded word, so their copies stay identical. A write is taken in one cycle and committed in the next, after its old-data lookups return. A bypass inside each bank hands a word being written straight to a read of the same address in the same cycle. This keeps back-to-back writes to one address from different ports consistent.

The ports are plain enables and addresses. Every port accepts a request in every cycle, so there is no back-pressure. Scheduling requests onto the ports is left to the surrounding logic.

Top module: `xor_mpram`

## Requirements
- R1: After reset, every address reads as zero on every read port.
- R2: An address on read port r in cycle t gives its data on rd_data slice r in cycle t+1. Read port r uses rd_addr bits [r*AW +: AW] and rd_data bits [r*DW +: DW].
- R3: A write accepted in cycle t is returned by every read issued in cycle t+1 or later, until another write to that address is accepted.
- R4: A read issued in the same cycle as a write to the same address returns the value held before that write.
- R5: Writes from all write ports in one cycle, each to a distinct address, are all retained. Write port p uses wr_en bit p, wr_addr bits [p*AW +: AW] and wr_data bits [p*DW +: DW]. Two enabled ports must never carry the same address in one cycle.
- R6: When different write ports write the same address in consecutive cycles, the later write is what later reads return.
- R7: Read ports are independent, and read ports given the same address in one cycle return the same word.
- R8: When no write is accepted in a cycle and a read address is held, the read data does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all banks |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write addresses, port p at [p*AW +: AW] |
| wr_data | input | NW*DW | Write data, port p at [p*DW +: DW] |
| rd_addr | input | NR*AW | Read addresses, port r at [r*AW +: AW] |
| rd_data | output | NR*DW | Read data one cycle after the address, port r at [r*DW +: DW] |

## Verification
Two functions can land in the same cycle. One is the commit of a write's encoded word. The other is a read, or another port's old-data lookup, at that same address. The bench provokes this with directed cases: a read issued together with a write to one address, a read one cycle after a write, and a chain of writes from different ports to one address in consecutive cycles. A long random run adds the same collisions at random. Each read result is judged against a reference array. Writes become visible to reads issued from the next cycle on, so the array is updated only after that cycle's expected read values have been taken.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  // index of the j-th port/set other than 'self'
  function automatic int other_idx(input int j, input int self);
    return (j < self) ? j : j + 1;
  endfunction

  // slot that port p occupies among the lookup banks of set s (p != s)
  function automatic int slot_of(input int p, input int s);
    return (p < s) ? p : p - 1;
  endfunction
endpackage

// File: rtl/xmp_bank.sv
module xmp_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write, one registered read; a same-address write is bypassed to the read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
    end
  end
endmodule

// File: rtl/xmp_wrset.sv
module xmp_wrset #(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NL   = NW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [NL*AW-1:0] lk_addr,
  output logic [NL*DW-1:0] lk_q,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_q
);
  // banks answering other write ports' old-data lookups
  for (genvar k = 0; k < NL; k++) begin : g_lk
    xmp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(lk_addr[k*AW +: AW]), .rdata(lk_q[k*DW +: DW]));
  end

  // banks answering the read ports
  for (genvar r = 0; r < NR; r++) begin : g_rd
    xmp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(rd_addr[r*AW +: AW]), .rdata(rd_q[r*DW +: DW]));
  end

  // R7
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_addr[AW-1:0] == rd_addr[AW-1:0]) |=> (lk_q[DW-1:0] == rd_q[DW-1:0]))
    else $error("set copies disagree");
endmodule

// File: rtl/xmp_encode.sv
module xmp_encode #(
  parameter int NW    = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NL   = NW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NL*DW-1:0] old_q,
  output logic             s2_we,
  output logic [AW-1:0]    s2_addr,
  output logic [DW-1:0]    s2_enc
);
  logic [DW-1:0] d_q;

  // hold the request while the other sets are looked up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_we   <= 1'b0;
      s2_addr <= '0;
      d_q     <= '0;
    end else begin
      s2_we   <= wr_en;
      s2_addr <= wr_addr;
      d_q     <= wr_data;
    end
  end

  always_comb begin
    s2_enc = d_q;
    for (int j = 0; j < NL; j++) s2_enc = s2_enc ^ old_q[j*DW +: DW];
  end
endmodule

// File: rtl/xmp_rd_merge.sv
module xmp_rd_merge #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int DW = 16
) (
  input  logic [NW*NR*DW-1:0] set_q,
  output logic [NR*DW-1:0]    rd_data
);
  always_comb begin
    rd_data = '0;
    for (int v = 0; v < NW; v++) rd_data = rd_data ^ set_q[v*NR*DW +: NR*DW];
  end
endmodule

// File: rtl/xor_mpram.sv
module xor_mpram #(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NL   = NW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);
  logic [NW-1:0]       s2_we;
  logic [NW*AW-1:0]    s2_addr;
  logic [NW*DW-1:0]    s2_enc;
  logic [NL*DW-1:0]    lk_q_v [NW];
  logic [NW*NR*DW-1:0] rd_all;

  // one bank set per write port
  for (genvar v = 0; v < NW; v++) begin : g_set
    logic [NL*AW-1:0] la;
    for (genvar j = 0; j < NL; j++) begin : g_la
      localparam int P = xmp_pkg::other_idx(j, v);
      assign la[j*AW +: AW] = wr_addr[P*AW +: AW];
    end
    xmp_wrset #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH)) u_set (
      .clk(clk), .rst_n(rst_n),
      .we(s2_we[v]), .waddr(s2_addr[v*AW +: AW]), .wdata(s2_enc[v*DW +: DW]),
      .lk_addr(la), .lk_q(lk_q_v[v]),
      .rd_addr(rd_addr), .rd_q(rd_all[v*NR*DW +: NR*DW]));
  end

  // encode path per write port: gather old words from every other set
  for (genvar w = 0; w < NW; w++) begin : g_wr
    logic [NL*DW-1:0] oq;
    for (genvar j = 0; j < NL; j++) begin : g_oq
      localparam int U = xmp_pkg::other_idx(j, w);
      localparam int S = xmp_pkg::slot_of(w, U);
      assign oq[j*DW +: DW] = lk_q_v[U][S*DW +: DW];
    end
    xmp_encode #(.NW(NW), .DW(DW), .DEPTH(DEPTH)) u_enc (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[w]), .wr_addr(wr_addr[w*AW +: AW]), .wr_data(wr_data[w*DW +: DW]),
      .old_q(oq),
      .s2_we(s2_we[w]), .s2_addr(s2_addr[w*AW +: AW]), .s2_enc(s2_enc[w*DW +: DW]));
  end

  xmp_rd_merge #(.NW(NW), .NR(NR), .DW(DW)) u_merge (
    .set_q(rd_all), .rd_data(rd_data));

  // R5
  for (genvar a = 0; a < NW; a++) begin : g_ua
    for (genvar b = a + 1; b < NW; b++) begin : g_ub
      addr_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[a] && wr_en[b]) |-> (wr_addr[a*AW +: AW] != wr_addr[b*AW +: AW]))
        else $error("two write ports share an address");
    end
  end

  // R3
  raw_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en[0]) && (rd_addr[AW-1:0] == $past(wr_addr[AW-1:0])))
      |=> (rd_data[DW-1:0] == $past(wr_data[DW-1:0], 2)))
    else $error("write not visible on the following read");

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(wr_en) == '0) && $stable(rd_addr)) |=> $stable(rd_data))
    else $error("read data moved with no write");
endmodule

// File: tb/xor_mpram_tb.sv
module xor_mpram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;
  localparam int NR = 2;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_mpram #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string tag, input int port, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s port %0d: got %h expected %h", tag, port, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  task automatic set_wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = a;
    wr_data[p*DW +: DW] = d;
  endtask

  task automatic set_rd(input int r, input logic [AW-1:0] a);
    rd_addr[r*AW +: AW] = a;
  endtask

  // one cycle: expected reads see writes of earlier cycles only
  task automatic issue(input string tag);
    logic [DW-1:0] e [NR];
    for (int r = 0; r < NR; r++) e[r] = ref_read(rd_addr[r*AW +: AW]);
    for (int p = 0; p < NW; p++)
      if (wr_en[p]) ref_mem[wr_addr[p*AW +: AW]] = wr_data[p*DW +: DW];
    @(negedge clk);
    for (int r = 0; r < NR; r++) check(tag, r, rd_data[r*DW +: DW], e[r]);
    wr_en = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all: watchdog expired, got hang expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] prev;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every address is zero after reset
    for (int a = 0; a < DEPTH; a += NR) begin
      for (int r = 0; r < NR; r++) set_rd(r, AW'((a + r) % DEPTH));
      issue("R1");
    end

    // R4: same-cycle read returns the old word
    set_wr(0, 4'd6, 16'hB00B); set_rd(0, 4'd6); set_rd(1, 4'd6);
    issue("R4");
    // R3: next-cycle read returns the new word
    issue("R3");
    set_wr(1, 4'd5, 16'hA5A5); set_rd(0, 4'd5);
    issue("R4");
    issue("R3");

    // R6: chain of writes to one address from different ports
    set_wr(0, 4'd7, 16'h1111); set_rd(0, 4'd7); set_rd(1, 4'd7);
    issue("R6");
    set_wr(2, 4'd7, 16'h2222);
    issue("R6");
    set_wr(1, 4'd7, 16'h3333);
    issue("R6");
    set_wr(0, 4'd7, 16'h4444);
    issue("R6");
    issue("R6");

    // R5: all ports write distinct addresses together
    set_wr(0, 4'd1, 16'hC001); set_wr(1, 4'd2, 16'hC002); set_wr(2, 4'd3, 16'hC003);
    set_rd(0, 4'd9);
    issue("R5");
    set_rd(0, 4'd1); set_rd(1, 4'd2);
    issue("R5");
    set_rd(0, 4'd3); set_rd(1, 4'd1);
    issue("R5");

    // R7: both read ports on one address agree
    set_rd(0, 4'd2); set_rd(1, 4'd2);
    issue("R7");
    check("R7", 1, rd_data[DW +: DW], rd_data[0 +: DW]);

    // R8: no write, held address, data holds
    set_rd(0, 4'd3); set_rd(1, 4'd7);
    issue("R8");
    prev = rd_data[0 +: DW];
    issue("R8");
    check("R8", 0, rd_data[0 +: DW], prev);

    // R2: random concurrent traffic against the reference array
    for (int n = 0; n < 3000; n++) begin
      bit used [DEPTH];
      for (int i = 0; i < DEPTH; i++) used[i] = 1'b0;
      for (int p = 0; p < NW; p++) begin
        if ($urandom % 2 == 1) begin
          logic [AW-1:0] a;
          a = AW'($urandom % DEPTH);
          while (used[a]) a = AW'($urandom % DEPTH);
          used[a] = 1'b1;
          set_wr(p, a, DW'($urandom));
        end
      end
      for (int r = 0; r < NR; r++) set_rd(r, AW'($urandom % DEPTH));
      issue("R2");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule